// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers thirteen interrupt sources: five from pins outside the chip and eight from on-chip peripherals. It turns them into a single interrupt line to a small CPU. A request that is high for a clock cycle latches a pending flag. Each flag stays set until software clears it, either by writing a one to its bit or by reading the 4-bit flag register that contains it. A read clears every flag in the nibble it returns.

A per-source mask decides which pending flags can raise the CPU line. A global enable bit gates the combined request as a whole. Software can clear the global enable, and the CPU's halt-entry strobe sets it again, so a halted core can always be woken. Requests and the register port are plain single-cycle strobes with no handshake. The controller never stalls either side, so there is no back-pressure to manage. The controller does not vector interrupts or rank them by priority.

Top module: `irq_hub`

## Requirements
- R1: After reset every flag, every mask bit and the global enable are 0, every register reads 0, and `cpu_irq` is 0.
- R2: Source bit i is `req_ext[i]` for i < 5 and `req_int[i-5]` for 5 ≤ i < 13. A high level on source i during a clock edge sets flag i at that edge, whether or not the source is masked. Flag i appears in flag register group i/4 at data bit i%4.
- R3: A flag keeps its value until it is cleared by a read or by a write. No other input changes it.
- R4: `cpu_irq` is 1 exactly when the global enable is 1 and at least one flag has its mask bit at 1. It follows the register state in the same cycle, so it can rise one edge after the request.
- R5: The address is `{space[1:0], group[1:0]}`. Space 0 holds the flags, space 1 the masks and space 2 the control register (group 0 only). `rdata` shows the addressed register in the same cycle without side effects. A cycle with `rd_en` high on a flag group clears all flags of that group at the next edge.
- R6: A write to a flag group clears the flags whose `wdata` bit is 1 and leaves the flags whose bit is 0 unchanged.
- R7: When a request arrives in the same cycle as a read-clear or write-clear of its flag, the flag is set after that edge.
- R8: A write to a mask group loads its mask bits from `wdata`. Mask bits with no source behind them (group 3, bits 1 to 3) read 0. Only mask writes change masks.
- R9: Bit 0 of the control register is the global enable and reads back as written. A `halt_enter` pulse sets it at the next edge. If `halt_enter` and a control write occur in the same cycle, `halt_enter` wins.
- R10: Space 3, and control space groups 1 to 3, read 0. Writes and reads there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ext | input | N_EXT (5) | External request strobes, source bits 0..4 |
| req_int | input | N_INT (8) | Internal request strobes, source bits 5..12 |
| halt_enter | input | 1 | CPU enters halt; sets the global enable |
| rd_en | input | 1 | Read strobe; clears the addressed flag group |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | `{space, group}` register address |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Addressed register, combinational |
| cpu_irq | output | 1 | Combined interrupt line to the CPU |

## Verification
Every piece of state in this block can be seen one edge after it changes. A flag or mask bit stuck high or low shows up in the next read of its group. If that bit is enabled, it also shows on `cpu_irq` in the same cycle. A wrong clear, such as one that reaches the wrong group, bit or space, is caught by a read on the following cycle. A lost collision, where a request is dropped when it meets a clear, leaves a zero at a bit where the bench expects a one. A wrong global enable is visible at once as a mismatch between `cpu_irq` and the flag-and-mask state the bench has written.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NIB = 4;

  typedef enum logic [1:0] {
    SP_FLAG = 2'd0,
    SP_MASK = 2'd1,
    SP_CTRL = 2'd2,
    SP_NONE = 2'd3
  } space_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int N  = 13,
  parameter int NG = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [NG-1:0]  rd_clr,
  input  logic [NG-1:0]  wr_clr,
  input  logic [NIB-1:0] wdata,
  output logic [N-1:0]   flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int G = i / NIB;
    localparam int P = i % NIB;
    logic kill;
    assign kill = rd_clr[G] | (wr_clr[G] & wdata[P]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= req[i] | (flags[i] & ~kill);
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_pkg::*;
#(
  parameter int N  = 13,
  parameter int NG = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NG-1:0]  wr_grp,
  input  logic [NIB-1:0] wdata,
  output logic [N-1:0]   masks
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int G = i / NIB;
    localparam int P = i % NIB;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         masks[i] <= 1'b0;
      else if (wr_grp[G]) masks[i] <= wdata[P];
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int N  = 13,
  parameter int NG = 4,
  parameter int GW = 2
) (
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [GW+1:0]  addr,
  input  logic [N-1:0]   flags,
  input  logic [N-1:0]   masks,
  input  logic           ge,
  output logic [NG-1:0]  rd_clr,
  output logic [NG-1:0]  wr_flag,
  output logic [NG-1:0]  wr_mask,
  output logic           wr_ctrl,
  output logic [NIB-1:0] rdata
);
  localparam int PADW = NG * NIB;

  space_e          space;
  logic [GW-1:0]   grp;
  logic [NG-1:0]   hit;
  logic [PADW-1:0] fpad;
  logic [PADW-1:0] mpad;

  assign space = space_e'(addr[GW+1:GW]);
  assign grp   = addr[GW-1:0];

  always_comb begin
    fpad = '0;
    mpad = '0;
    fpad[N-1:0] = flags;
    mpad[N-1:0] = masks;
    for (int g = 0; g < NG; g++) begin
      hit[g]     = (grp == GW'(g));
      rd_clr[g]  = rd_en & (space == SP_FLAG) & hit[g];
      wr_flag[g] = wr_en & (space == SP_FLAG) & hit[g];
      wr_mask[g] = wr_en & (space == SP_MASK) & hit[g];
    end
  end

  assign wr_ctrl = wr_en & (space == SP_CTRL) & (grp == '0);

  always_comb begin
    rdata = '0;
    unique case (space)
      SP_FLAG: for (int g = 0; g < NG; g++) if (hit[g]) rdata = fpad[g*NIB +: NIB];
      SP_MASK: for (int g = 0; g < NG; g++) if (hit[g]) rdata = mpad[g*NIB +: NIB];
      SP_CTRL: if (grp == '0) rdata = {{(NIB-1){1'b0}}, ge};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int N_EXT = 5,
  parameter int N_INT = 8,
  localparam int N  = N_EXT + N_INT,
  localparam int NG = (N + NIB - 1) / NIB,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int AW = GW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_ext,
  input  logic [N_INT-1:0] req_int,
  input  logic             halt_enter,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NIB-1:0]   wdata,
  output logic [NIB-1:0]   rdata,
  output logic             cpu_irq
);
  logic [N-1:0]  req;
  logic [N-1:0]  flags;
  logic [N-1:0]  masks;
  logic [NG-1:0] rd_clr;
  logic [NG-1:0] wr_flag;
  logic [NG-1:0] wr_mask;
  logic          wr_ctrl;
  logic          ge;

  assign req = {req_int, req_ext};

  irq_regif #(.N(N), .NG(NG), .GW(GW)) u_regif (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .flags(flags), .masks(masks), .ge(ge),
    .rd_clr(rd_clr), .wr_flag(wr_flag), .wr_mask(wr_mask),
    .wr_ctrl(wr_ctrl), .rdata(rdata)
  );

  irq_flag_bank #(.N(N), .NG(NG)) u_flags (
    .clk(clk), .rst_n(rst_n), .req(req),
    .rd_clr(rd_clr), .wr_clr(wr_flag), .wdata(wdata), .flags(flags)
  );

  irq_mask_bank #(.N(N), .NG(NG)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_grp(wr_mask), .wdata(wdata), .masks(masks)
  );

  // Halt entry re-arms the global enable and overrides a same-cycle write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ge <= 1'b0;
    else if (halt_enter) ge <= 1'b1;
    else if (wr_ctrl)    ge <= wdata[0];
  end

  assign cpu_irq = ge & (|(flags & masks));
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_EXT = 5,
  parameter int N_INT = 8,
  localparam int N = N_EXT + N_INT
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EXT-1:0] req_ext,
  input logic [N_INT-1:0] req_int,
  input logic             halt_enter,
  input logic             rd_en,
  input logic             wr_en,
  input logic             cpu_irq,
  input logic [N-1:0]     flags,
  input logic [N-1:0]     masks,
  input logic             ge
);
  logic [N-1:0] req;
  assign req = {req_int, req_ext};

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && !rd_en && !wr_en) |=> $stable(flags)); // R3

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((flags & $past(req)) == $past(req))); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags & masks) == '0) || !ge) |-> !cpu_irq); // R4

  AST_HALT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> ge); // R9

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(masks)); // R8
endmodule

bind irq_hub irq_hub_chk #(.N_EXT(N_EXT), .N_INT(N_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_int(req_int),
  .halt_enter(halt_enter), .rd_en(rd_en), .wr_en(wr_en), .cpu_irq(cpu_irq),
  .flags(flags), .masks(masks), .ge(ge)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  localparam int N_EXT = 5;
  localparam int N_INT = 8;
  localparam int N     = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_EXT-1:0] req_ext = '0;
  logic [N_INT-1:0] req_int = '0;
  logic halt_enter = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic [3:0] rdata;
  logic cpu_irq;
  int n_run = 0, n_fail = 0;
  logic [3:0] v;

  always #2.5 clk = ~clk;

  irq_hub u0 (.clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_int(req_int),
    .halt_enter(halt_enter), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq));

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic peek(input int sp, input int g, output logic [3:0] d);
    addr = 4'(sp * 4 + g); rd_en = 1'b0; wr_en = 1'b0;
    #1 d = rdata;
    step();
  endtask

  task automatic wr(input int sp, input int g, input logic [3:0] d);
    addr = 4'(sp * 4 + g); wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rdclr(input int g);
    addr = 4'(g); rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic set_req(input int i);
    logic [N-1:0] s;
    s = N'(1) << i;
    req_ext = s[4:0]; req_int = s[12:5];
  endtask

  task automatic pulse(input int i);
    set_req(i); step(); req_ext = '0; req_int = '0;
  endtask

  function automatic logic [3:0] valid(input int g);
    return (g == 3) ? 4'b0001 : 4'b1111;
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    for (int s = 0; s < 3; s++)
      for (int g = 0; g < 4; g++) begin
        peek(s, g, v); chk("R1 reset register", v, 4'h0);
      end
    chk("R1 cpu_irq after reset", {3'b0, cpu_irq}, 4'h0);

    // R2 / R5: every source latches at its own bit, read clears
    for (int i = 0; i < N; i++) begin
      pulse(i);
      chk("R2 masked flag keeps line low", {3'b0, cpu_irq}, 4'h0);
      peek(0, i / 4, v); chk("R2 flag position", v, 4'(1 << (i % 4)));
      peek(0, i / 4, v); chk("R5 plain peek has no side effect", v, 4'(1 << (i % 4)));
      rdclr(i / 4);
      peek(0, i / 4, v); chk("R5 read clears group", v, 4'h0);
    end

    // R8 mask sweep, all values in every group
    for (int g = 0; g < 4; g++) begin
      for (int d = 0; d < 16; d++) begin
        wr(1, g, 4'(d));
        peek(1, g, v); chk("R8 mask readback", v, 4'(d) & valid(g));
      end
      wr(1, g, 4'h0);
    end

    // R4 / R6: line follows flag AND mask with global enable on
    wr(2, 0, 4'h1);
    for (int i = 0; i < N; i++)
      for (int m = 0; m < 2; m++) begin
        wr(1, i / 4, (m == 1) ? 4'(1 << (i % 4)) : 4'h0);
        pulse(i);
        chk("R4 cpu_irq per source and mask", {3'b0, cpu_irq}, 4'(m));
        wr(0, i / 4, 4'(1 << (i % 4)));
        chk("R6 write-one clears line", {3'b0, cpu_irq}, 4'h0);
        peek(0, i / 4, v); chk("R6 write-one clears flag", v, 4'h0);
        wr(1, i / 4, 4'h0);
      end

    // R3 flags hold while idle; R6 selective clear
    req_ext = 5'b01111; step(); req_ext = '0;
    for (int k = 0; k < 5; k++) step();
    peek(0, 0, v); chk("R3 flags hold", v, 4'hF);
    wr(0, 0, 4'b0101);
    peek(0, 0, v); chk("R6 selective clear", v, 4'b1010);
    rdclr(0);

    // R7 collisions
    req_ext = 5'b00001; addr = 4'h0; rd_en = 1'b1; step(); rd_en = 1'b0; req_ext = '0;
    peek(0, 0, v); chk("R7 request beats read-clear", v, 4'b0001);
    req_ext = 5'b00001; addr = 4'h0; wdata = 4'h1; wr_en = 1'b1; step(); wr_en = 1'b0; req_ext = '0;
    peek(0, 0, v); chk("R7 request beats write-clear", v, 4'b0001);

    // R9 global enable
    wr(1, 0, 4'h1);
    chk("R9 enable on, line high", {3'b0, cpu_irq}, 4'h1);
    wr(2, 0, 4'h0);
    chk("R9 enable off, line low", {3'b0, cpu_irq}, 4'h0);
    peek(2, 0, v); chk("R9 control readback 0", v, 4'h0);
    halt_enter = 1'b1; step(); halt_enter = 1'b0;
    chk("R9 halt re-arms line", {3'b0, cpu_irq}, 4'h1);
    peek(2, 0, v); chk("R9 control readback 1", v, 4'h1);
    halt_enter = 1'b1; addr = 4'h8; wdata = 4'h0; wr_en = 1'b1; step();
    halt_enter = 1'b0; wr_en = 1'b0;
    peek(2, 0, v); chk("R9 halt beats write", v, 4'h1);

    // R10 unused addresses
    for (int g = 0; g < 4; g++) begin
      wr(3, g, 4'hF);
      addr = 4'(12 + g); rd_en = 1'b1; step(); rd_en = 1'b0;
      peek(3, g, v); chk("R10 space 3 reads 0", v, 4'h0);
    end
    for (int g = 1; g < 4; g++) begin
      wr(2, g, 4'h0);
      peek(2, g, v); chk("R10 control groups 1-3 read 0", v, 4'h0);
    end
    peek(0, 0, v); chk("R10 flags untouched", v, 4'b0001);
    peek(1, 0, v); chk("R10 masks untouched", v, 4'b0001);
    peek(2, 0, v); chk("R10 enable untouched", v, 4'h1);
    chk("R10 line untouched", {3'b0, cpu_irq}, 4'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule